// File: doc/BRIEF.md
# ADC Reference, Scan Status and Interrupt Register

This block is one 32-bit control and status word for an analog-to-digital converter, reached over a simple bus with separate read and write strobes and per-byte lane enables. Three flags are owned by hardware: a reference-ready flag, a sticky reference-fault flag and an end-of-scan flag. Each has its own rule for clearing. The remaining implemented bits are plain read/write configuration: three interrupt enables, a 3-bit line-capacitance code, a 10-bit sample-time count, a 3-bit early-interrupt lead and a 7-bit clock-divide code. The block stores the timing fields for the converter to use but does not interpret them.

The ready flag comes from a three-state machine. REF_OFF holds while the module enable is low. REF_WAIT holds while the block is enabled but the reference is not yet good. REF_UP holds while the block is enabled and the reference is good. The transitions are as follows. Any state goes to REF_OFF when the enable drops. REF_OFF goes to REF_WAIT on enable with the reference not good, and to REF_UP on enable with the reference good. REF_WAIT goes to REF_UP when the reference becomes good. REF_UP goes to REF_WAIT when the reference is lost. The ready flag reads 1 only in REF_UP.

A single interrupt request is raised, one cycle late, whenever any flag and its enable are both 1. The word answers at one bus address; other addresses read as zero and ignore writes.

Top module: `adc_stat_reg`

## Requirements
- R1: After reset every bit of the word reads 0 and the interrupt output is 0.
- R2: The ready flag (bit 31) is 1 in the cycle after the module enable and the reference-good input are both 1. It is 0 in the cycle after the module enable is 0, or after the reference-good input is 0.
- R3: The fault flag (bit 30) is set in the cycle after the fault input is 1 while the module enable is 1. A fault input while the module enable is 0 leaves it at 0.
- R4: Once set, the fault flag stays set until a cycle in which the module enable is 0 and the ready flag is 1. Disabling while the ready flag is 0 leaves it set.
- R5: A one-cycle scan-complete pulse sets the end-of-scan flag (bit 29), which then holds.
- R6: A read at the register address with byte lane 3 (bits 31:24) enabled returns the flag and then clears it after that edge. Reads without lane 3, or at another address, leave it set.
- R7: When a scan-complete pulse and a clearing read fall in the same cycle, the flag ends set.
- R8: Writes update only the enabled byte lanes. The writable bits are 28:16, 15:13, 10:8 and 6:0 (mask 0x1FFFE77F). Bits 12:11 and 7 read as 0.
- R9: Bus writes to bits 31:29 have no effect on the flags.
- R10: The interrupt output is 1 in the cycle after any of (bit 31 and bit 15), (bit 30 and bit 14), (bit 29 and bit 13) is 1. Otherwise it is 0.
- R11: Writes to any other address change nothing, and reads at any other address return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_addr | input | ADDR_W | Byte address of the access |
| bus_wr_en | input | 1 | Write strobe |
| bus_rd_en | input | 1 | Read strobe (qualifies clear-on-read) |
| bus_be | input | 4 | Byte lane enables, lane 3 is bits 31:24 |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational from the address |
| mod_en | input | 1 | Converter module enable from another register |
| ref_ok | input | 1 | Band gap and reference both ready |
| ref_fault | input | 1 | Reference or band gap fault indication |
| scan_done | input | 1 | One-cycle pulse when the scan list completes |
| irq | output | 1 | Registered interrupt request |

## Verification
The bench disables the block before the reference is ready and checks that the fault stays latched. A design that cleared the fault on disable alone would lose it. It lands a scan pulse on the same edge as a clearing read, where a clear-priority design would drop the new event. It also issues reads that miss lane 3 or the address, which a sloppy decode would treat as clearing. Sweeps over every lane-enable pattern and every enable and flag combination catch writable reserved bits, writable flags and interrupt terms wired to the wrong enable.

// File: rtl/adc_stat_pkg.sv
package adc_stat_pkg;
    localparam int REG_W  = 32;
    localparam int NLANE  = REG_W / 8;
    localparam logic [REG_W-1:0] CFG_WMASK = 32'h1FFF_E77F;
    localparam int BIT_RDY = 31;
    localparam int BIT_FLT = 30;
    localparam int BIT_EOS = 29;
    localparam int IEN_RDY = 15;
    localparam int IEN_FLT = 14;
    localparam int IEN_EOS = 13;
    localparam int RD_CLR_LANE = 3;

    typedef enum logic [1:0] {
        REF_OFF  = 2'd0,
        REF_WAIT = 2'd1,
        REF_UP   = 2'd2
    } ref_state_e;

    typedef struct packed {
        logic rdy;
        logic flt;
        logic eos;
    } stat_flags_t;
endpackage

// File: rtl/adc_ref_fsm.sv
module adc_ref_fsm
    import adc_stat_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic mod_en,
    input  logic ref_ok,
    input  logic fault_in,
    output logic ready,
    output logic fault
);
    ref_state_e state_q, state_d;
    logic       fault_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= REF_OFF;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            REF_OFF: begin
                if (mod_en) state_d = ref_ok ? REF_UP : REF_WAIT;
            end
            REF_WAIT: begin
                if (!mod_en)     state_d = REF_OFF;
                else if (ref_ok) state_d = REF_UP;
            end
            REF_UP: begin
                if (!mod_en)     state_d = REF_OFF;
                else if (!ref_ok) state_d = REF_WAIT;
            end
            default: state_d = REF_OFF;
        endcase
    end

    always_comb begin
        ready = (state_q == REF_UP);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                  fault_q <= 1'b0;
        else if (mod_en && fault_in) fault_q <= 1'b1;
        else if (!mod_en && ready)   fault_q <= 1'b0;
    end

    assign fault = fault_q;

    AST_RDY_OFF:   assert property (@(posedge clk) disable iff (!rst_n) !mod_en |=> !ready); // R2
    AST_RDY_UP:    assert property (@(posedge clk) disable iff (!rst_n) (mod_en && ref_ok) |=> ready); // R2
    AST_FLT_SET:   assert property (@(posedge clk) disable iff (!rst_n) (mod_en && fault_in) |=> fault); // R3
    AST_FLT_NOSET: assert property (@(posedge clk) disable iff (!rst_n) (!fault && !(mod_en && fault_in)) |=> !fault); // R3
    AST_FLT_HOLD:  assert property (@(posedge clk) disable iff (!rst_n) (fault && (mod_en || !ready)) |=> fault); // R4
endmodule

// File: rtl/adc_eos_flag.sv
module adc_eos_flag (
    input  logic clk,
    input  logic rst_n,
    input  logic scan_done,
    input  logic rd_clr,
    output logic eos
);
    logic eos_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)         eos_q <= 1'b0;
        else if (scan_done) eos_q <= 1'b1;
        else if (rd_clr)    eos_q <= 1'b0;
    end

    assign eos = eos_q;

    AST_EOS_SET:   assert property (@(posedge clk) disable iff (!rst_n) scan_done |=> eos); // R5 R7
    AST_EOS_HOLD:  assert property (@(posedge clk) disable iff (!rst_n) (eos && !rd_clr) |=> eos); // R5
    AST_EOS_CLR:   assert property (@(posedge clk) disable iff (!rst_n) (rd_clr && !scan_done) |=> !eos); // R6
    AST_EOS_QUIET: assert property (@(posedge clk) disable iff (!rst_n) (!eos && !scan_done) |=> !eos); // R5
endmodule

// File: rtl/adc_cfg_bank.sv
module adc_cfg_bank
    import adc_stat_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_go,
    input  logic [NLANE-1:0] lane_en,
    input  logic [REG_W-1:0] wdata,
    output logic [REG_W-1:0] cfg
);
    logic [REG_W-1:0] cfg_q;

    for (genvar l = 0; l < NLANE; l++) begin : g_lane
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
                cfg_q[l*8 +: 8] <= 8'h00;
            else if (wr_go && lane_en[l])
                cfg_q[l*8 +: 8] <= wdata[l*8 +: 8] & CFG_WMASK[l*8 +: 8];
        end

        AST_LANE_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
            !(wr_go && lane_en[l]) |=> $stable(cfg_q[l*8 +: 8])); // R8
    end

    assign cfg = cfg_q;

    AST_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n) !wr_go |=> $stable(cfg)); // R11
    AST_RSVD_ZERO: assert property (@(posedge clk) disable iff (!rst_n) 1'b1 |=> ((cfg & ~CFG_WMASK) == '0)); // R8
endmodule

// File: rtl/adc_stat_reg.sv
module adc_stat_reg
    import adc_stat_pkg::*;
#(
    parameter int              ADDR_W     = 8,
    parameter logic [ADDR_W-1:0] REG_OFFSET = 8'h10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr_en,
    input  logic              bus_rd_en,
    input  logic [3:0]        bus_be,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    input  logic              mod_en,
    input  logic              ref_ok,
    input  logic              ref_fault,
    input  logic              scan_done,
    output logic              irq
);
    logic        hit;
    logic        wr_go;
    logic        rd_clr;
    logic [31:0] cfg;
    stat_flags_t flags;
    stat_flags_t ien;
    logic        irq_q;

    assign hit    = (bus_addr == REG_OFFSET);
    assign wr_go  = hit && bus_wr_en;
    assign rd_clr = hit && bus_rd_en && bus_be[RD_CLR_LANE];

    adc_ref_fsm u_ref (
        .clk      (clk),
        .rst_n    (rst_n),
        .mod_en   (mod_en),
        .ref_ok   (ref_ok),
        .fault_in (ref_fault),
        .ready    (flags.rdy),
        .fault    (flags.flt)
    );

    adc_eos_flag u_eos (
        .clk       (clk),
        .rst_n     (rst_n),
        .scan_done (scan_done),
        .rd_clr    (rd_clr),
        .eos       (flags.eos)
    );

    adc_cfg_bank u_cfg (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_go   (wr_go),
        .lane_en (bus_be),
        .wdata   (bus_wdata),
        .cfg     (cfg)
    );

    assign ien = '{rdy: cfg[IEN_RDY], flt: cfg[IEN_FLT], eos: cfg[IEN_EOS]};

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) irq_q <= 1'b0;
        else        irq_q <= |(flags & ien);
    end

    assign irq = irq_q;

    always_comb begin
        bus_rdata = '0;
        if (hit) begin
            bus_rdata = cfg;
            bus_rdata[BIT_RDY] = flags.rdy;
            bus_rdata[BIT_FLT] = flags.flt;
            bus_rdata[BIT_EOS] = flags.eos;
        end
    end

    AST_IRQ_RISE: assert property (@(posedge clk) disable iff (!rst_n)
        ((flags.rdy && cfg[IEN_RDY]) || (flags.flt && cfg[IEN_FLT]) || (flags.eos && cfg[IEN_EOS])) |=> irq); // R10
    AST_IRQ_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !((flags.rdy && cfg[IEN_RDY]) || (flags.flt && cfg[IEN_FLT]) || (flags.eos && cfg[IEN_EOS])) |=> !irq); // R10
    AST_MISS_ZERO: assert property (@(posedge clk) disable iff (!rst_n) !hit |-> (bus_rdata == '0)); // R11
endmodule

// File: tb/adc_stat_reg_tb.sv
`timescale 1ns/1ps
module adc_stat_reg_tb;
    localparam logic [31:0] WMASK = 32'h1FFF_E77F;
    localparam logic [7:0]  RADDR = 8'h10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  bus_addr = 8'h00;
    logic        bus_wr_en = 1'b0;
    logic        bus_rd_en = 1'b0;
    logic [3:0]  bus_be = 4'h0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        mod_en = 1'b0;
    logic        ref_ok = 1'b0;
    logic        ref_fault = 1'b0;
    logic        scan_done = 1'b0;
    logic        irq;

    int total = 0;
    int bad = 0;
    logic [31:0] exp_cfg = '0;
    logic [31:0] rv;

    always #2.5 clk = ~clk;

    adc_stat_reg u_dut (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr_en(bus_wr_en),
        .bus_rd_en(bus_rd_en), .bus_be(bus_be), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .mod_en(mod_en), .ref_ok(ref_ok),
        .ref_fault(ref_fault), .scan_done(scan_done), .irq(irq)
    );

    task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
        total++;
        if (got !== exp) begin
            bad++;
            $display("FAIL %s got=%h exp=%h", tag, got, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic peek(input logic [7:0] a, output logic [31:0] d);
        bus_addr = a;
        bus_rd_en = 1'b0;
        #1;
        d = bus_rdata;
    endtask

    task automatic bus_write(input logic [7:0] a, input logic [31:0] d, input logic [3:0] be);
        bus_addr = a; bus_wdata = d; bus_be = be; bus_wr_en = 1'b1;
        tick();
        bus_wr_en = 1'b0; bus_be = 4'h0;
    endtask

    task automatic bus_read(input logic [7:0] a, input logic [3:0] be, output logic [31:0] d);
        bus_addr = a; bus_be = be; bus_rd_en = 1'b1;
        #1;
        d = bus_rdata;
        tick();
        bus_rd_en = 1'b0; bus_be = 4'h0;
    endtask

    function automatic logic [31:0] lane_mask(input logic [3:0] be);
        logic [31:0] m = '0;
        for (int l = 0; l < 4; l++) if (be[l]) m[l*8 +: 8] = 8'hFF;
        return m;
    endfunction

    function automatic logic [31:0] with_flags(input logic r, input logic f, input logic e);
        return (exp_cfg & 32'h1FFF_FFFF) | {r, f, e, 29'b0};
    endfunction

    initial begin
        #(200000 * 5);
        bad++; total++;
        $display("FAIL watchdog expired");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic [31:0] pats [4];
        pats[0] = 32'hFFFF_FFFF; pats[1] = 32'h0000_0000;
        pats[2] = 32'hA5A5_5A5A; pats[3] = 32'h5A5A_A5A5;
        repeat (3) tick();
        rst_n = 1'b1;
        tick();

        // R1 reset state
        peek(RADDR, rv);
        check("R1 reset word", rv, 32'h0);
        check("R1 reset irq", {31'b0, irq}, 32'h0);

        // R8 R9 sweep over every lane pattern and data pattern
        for (int be = 0; be < 16; be++) begin
            for (int p = 0; p < 4; p++) begin
                bus_write(RADDR, pats[p], be[3:0]);
                exp_cfg = (exp_cfg & ~lane_mask(be[3:0])) | (pats[p] & lane_mask(be[3:0]) & WMASK);
                peek(RADDR, rv);
                check("R8 R9 lane write", rv, exp_cfg);
            end
        end

        // R11 other address
        bus_write(8'h14, 32'hFFFF_FFFF, 4'hF);
        peek(RADDR, rv);
        check("R11 foreign write", rv, exp_cfg);
        peek(8'h14, rv);
        check("R11 foreign read", rv, 32'h0);

        // clear interrupt enables for the flag tests
        bus_write(RADDR, 32'h0, 4'b0010);
        exp_cfg[15:8] = 8'h00;

        // R2 ready flag
        mod_en = 1'b1; ref_ok = 1'b0;
        tick(); tick();
        peek(RADDR, rv);
        check("R2 enabled not ready", rv, with_flags(0, 0, 0));
        ref_ok = 1'b1;
        tick();
        peek(RADDR, rv);
        check("R2 ready one cycle", rv, with_flags(1, 0, 0));
        mod_en = 1'b0;
        tick();
        peek(RADDR, rv);
        check("R2 disable drops ready", rv, with_flags(0, 0, 0));
        mod_en = 1'b1;
        tick();
        ref_ok = 1'b0;
        tick();
        peek(RADDR, rv);
        check("R2 ref lost drops ready", rv, with_flags(0, 0, 0));

        // R3 fault ignored while disabled
        mod_en = 1'b0; tick();
        ref_fault = 1'b1; tick(); ref_fault = 1'b0;
        peek(RADDR, rv);
        check("R3 fault ignored when off", rv, with_flags(0, 0, 0));
        // R3 fault latched while enabled
        mod_en = 1'b1; ref_ok = 1'b1; tick();
        ref_fault = 1'b1; tick(); ref_fault = 1'b0;
        tick(); tick();
        peek(RADDR, rv);
        check("R3 fault latched", rv, with_flags(1, 1, 0));
        // R4 disable while not ready keeps fault
        ref_ok = 1'b0; tick();
        mod_en = 1'b0; tick(); tick();
        peek(RADDR, rv);
        check("R4 fault kept when not ready", rv, with_flags(0, 1, 0));
        // R4 disable while ready clears fault
        mod_en = 1'b1; ref_ok = 1'b1; tick();
        peek(RADDR, rv);
        check("R4 fault survives re-enable", rv, with_flags(1, 1, 0));
        mod_en = 1'b0; tick();
        peek(RADDR, rv);
        check("R4 fault cleared", rv, with_flags(0, 0, 0));

        // R5 end of scan
        scan_done = 1'b1; tick(); scan_done = 1'b0;
        tick(); tick();
        peek(RADDR, rv);
        check("R5 eos held", rv, with_flags(0, 0, 1));
        // R6 reads that must not clear
        bus_read(RADDR, 4'b0111, rv);
        peek(RADDR, rv);
        check("R6 read without lane 3", rv, with_flags(0, 0, 1));
        bus_read(8'h14, 4'b1000, rv);
        peek(RADDR, rv);
        check("R6 read other address", rv, with_flags(0, 0, 1));
        // R6 clearing read
        bus_read(RADDR, 4'b1000, rv);
        check("R6 read returns flag", rv, with_flags(0, 0, 1));
        peek(RADDR, rv);
        check("R6 cleared after read", rv, with_flags(0, 0, 0));
        // R7 set wins
        scan_done = 1'b1;
        bus_read(RADDR, 4'b1000, rv);
        scan_done = 1'b0;
        peek(RADDR, rv);
        check("R7 set beats clear", rv, with_flags(0, 0, 1));
        // R9 flags not writable
        bus_write(RADDR, 32'h0000_0000, 4'b1000);
        exp_cfg[31:24] = 8'h00;
        bus_write(RADDR, 32'hE000_0000, 4'b1000);
        peek(RADDR, rv);
        check("R9 flag write ignored", rv, with_flags(0, 0, 1));

        // R10 all three flags set
        mod_en = 1'b1; ref_ok = 1'b1;
        ref_fault = 1'b1; tick(); ref_fault = 1'b0;
        tick();
        check("R10 no enables no irq", {31'b0, irq}, 32'h0);
        bus_write(RADDR, 32'h7 << 13, 4'b0010);
        check("R10 irq one cycle late", {31'b0, irq}, 32'h0);
        tick();
        check("R10 irq raised", {31'b0, irq}, 32'h1);
        for (int ph = 0; ph < 3; ph++) begin
            logic [2:0] fl;
            if (ph == 1) bus_read(RADDR, 4'b1000, rv);
            if (ph == 2) begin mod_en = 1'b0; tick(); end
            fl = (ph == 0) ? 3'b111 : (ph == 1) ? 3'b110 : 3'b000;
            for (int e = 0; e < 8; e++) begin
                bus_write(RADDR, 32'(e) << 13, 4'b0010);
                tick();
                check($sformatf("R10 flags=%b en=%b", fl, e[2:0]), {31'b0, irq}, {31'b0, |(fl & e[2:0])});
            end
        end

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule